// File: doc/BRIEF.md
# Audio Subframe Filter and Formatter

This block sits between a biphase line decoder and a receive FIFO in a digital audio receiver. It takes one decoded subframe per input transfer: a 24-bit audio payload, the validity, user, channel status and parity bits, bit 1 of channel status byte 0, and the preamble type that opened the subframe. For each subframe it decides whether the sample is kept. Three rules can drop a sample: a missing block start, a set validity bit and a parity mismatch. Each rule has its own enable.

A kept sample is turned into a 32-bit word for the FIFO. There are two layouts. The unpacked layout carries the sample together with its status bits and a frame-type code. The packed layout carries payload only. Its alignment follows the selected width, and in 16-bit mode two samples share one word. Samples enter on a valid/ready stream and words leave on a second valid/ready stream. A single output register sits between them, so the input is ready whenever that register is empty or is being emptied in the same cycle. A sticky flag reports parity failures.

Top module: `subframe_fmt`

## Requirements
- R1: While `cfg_en` is low, input subframes are still consumed but no word is produced. Any half-filled 16-bit pair is discarded, and the block-start history is forgotten.
- R2: With `cfg_blk_gate` set, samples are dropped until a subframe with preamble code 0 (block start) has been consumed since enable went high. That subframe and all later ones pass this rule. With `cfg_blk_gate` clear, the preamble never causes a drop.
- R3: With `cfg_vld_gate` set, a sample whose `s_v` is 1 is dropped. With it clear, `s_v` never causes a drop.
- R4: Parity is even over the payload and the V, U, C and P bits, so the count of ones across those 28 bits must be even. With `cfg_par_chk` set, a failing sample is dropped and sets `par_err`. With it clear, parity neither drops a sample nor sets the flag.
- R5: `par_err` stays high until `err_clr` is pulsed. A new parity failure in the same cycle as `err_clr` wins over the clear.
- R6: Width code 1 keeps the upper 20 payload bits and code 2 keeps the upper 16 bits. Dropped low bits are zero. Codes 0 and 3 keep all 24 bits.
- R7: In unpacked mode (`cfg_pack`=0) the word is laid out as follows: the payload is in [23:0], V in bit 24, U in bit 25, C in bit 26, P in bit 27, the channel status byte 0 bit 1 in bit 28, and the preamble code in [30:29] (0 block start, 1 first channel, 2 second channel). Bit 31 is zero.
- R8: In packed mode the 24-bit word is the payload in [23:0] with zeros above it. The 20-bit word is the upper 20 payload bits in [19:0] with zeros above them.
- R9: In packed 16-bit mode, two consecutive kept samples form one word. The upper 16 bits of the first sample go in [15:0] and those of the second go in [31:16]. A word is emitted only on every second kept sample.
- R10: With `cfg_big_endian` set and width code 0 or 3, the three payload bytes are reversed within the payload field, in both layouts.
- R11: `s_ready` is high exactly when `m_valid` is low or `m_ready` is high. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Receive enable |
| cfg_blk_gate | input | 1 | Drop samples until a block start has been seen |
| cfg_vld_gate | input | 1 | Drop samples whose validity bit is set |
| cfg_par_chk | input | 1 | Enable the parity check |
| cfg_width | input | 2 | Width code: 0 = 24 bits, 1 = 20 bits, 2 = 16 bits, 3 = 24 bits |
| cfg_pack | input | 1 | Packed layout select |
| cfg_big_endian | input | 1 | Reverse payload bytes for 24-bit samples |
| err_clr | input | 1 | Clear the parity error flag |
| s_valid | input | 1 | Subframe available |
| s_ready | output | 1 | Subframe consumed this cycle if valid |
| s_payload | input | 24 | Audio payload |
| s_v | input | 1 | Validity bit |
| s_u | input | 1 | User bit |
| s_c | input | 1 | Channel status bit |
| s_p | input | 1 | Parity bit |
| s_cs_b0b1 | input | 1 | Channel status byte 0, bit 1 |
| s_pre | input | 2 | Preamble code: 0 block start, 1 first channel, 2 second channel |
| m_valid | output | 1 | Output word available |
| m_ready | input | 1 | FIFO accepts the word |
| m_data | output | 32 | Formatted output word |
| par_err | output | 1 | Sticky parity error flag |

## Verification
The hardest situations to reach are those where several conditions must line up at once. One is a 16-bit pair whose halves are split by a stall, by a sample dropped in between, or by enable going low. Another is a parity failure that lands on the same edge as a clear. The stimulus mixes random stalls on `m_ready` with sparse block-start preambles, set validity bits and corrupted parity bits. It runs through directed configurations and then random ones, so that drops, stalls and pairing overlap often. A bench model tracks the pending half, the block-start history and the error flag to predict every word.

// File: rtl/sff_pkg.sv
package sff_pkg;
  localparam int PAY_W  = 24;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    PRE_BLK = 2'd0,
    PRE_CHA = 2'd1,
    PRE_CHB = 2'd2
  } pre_e;

  typedef enum logic [1:0] {
    WID_24  = 2'd0,
    WID_20  = 2'd1,
    WID_16  = 2'd2,
    WID_RSV = 2'd3
  } wid_e;
endpackage

// File: rtl/sff_gate.sv
module sff_gate
  import sff_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             blk_gate,
  input  logic             vld_gate,
  input  logic             par_chk,
  input  logic             err_clr,
  input  logic             fire,
  input  logic [PAY_W-1:0] payload,
  input  logic             v,
  input  logic             u,
  input  logic             c,
  input  logic             p,
  input  logic [1:0]       pre,
  output logic             keep,
  output logic             perr
);
  logic blk_seen;
  logic is_blk;
  logic par_bad;
  logic pass_blk, pass_vld, pass_par;

  assign is_blk   = (pre == PRE_BLK);
  assign par_bad  = ^{payload, v, u, c, p};
  assign pass_blk = !blk_gate || blk_seen || is_blk;
  assign pass_vld = !vld_gate || !v;
  assign pass_par = !par_chk || !par_bad;
  assign keep     = en && pass_blk && pass_vld && pass_par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_seen <= 1'b0;
    end else if (!en) begin
      blk_seen <= 1'b0;
    end else if (fire && is_blk) begin
      blk_seen <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr <= 1'b0;
    end else if (fire && en && par_chk && par_bad) begin
      perr <= 1'b1;
    end else if (err_clr) begin
      perr <= 1'b0;
    end
  end

  // R4
  perr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(perr) |-> $past(par_chk) && $past(fire));

  // R5
  perr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr) |-> $past(err_clr));
endmodule

// File: rtl/sff_fmt.sv
module sff_fmt
  import sff_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        width,
  input  logic              pack,
  input  logic              big_endian,
  input  logic [PAY_W-1:0]  payload,
  input  logic              v,
  input  logic              u,
  input  logic              c,
  input  logic              p,
  input  logic              cs_b0b1,
  input  logic [1:0]        pre,
  output logic [WORD_W-1:0] word,
  output logic [HALF_W-1:0] half
);
  localparam int NBYTE = PAY_W / 8;

  logic [PAY_W-1:0] masked;
  logic [PAY_W-1:0] swapped;
  logic [PAY_W-1:0] field;
  logic             full_w;

  assign full_w = (width == WID_24) || (width == WID_RSV);

  always_comb begin
    masked = payload;
    case (width)
      WID_20:  masked[3:0] = '0;
      WID_16:  masked[7:0] = '0;
      default: masked = payload;
    endcase
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_swap
    assign swapped[b*8 +: 8] = payload[(NBYTE-1-b)*8 +: 8];
  end

  assign field = (full_w && big_endian) ? swapped : masked;
  assign half  = payload[PAY_W-1 -: HALF_W];

  always_comb begin
    word = '0;
    if (!pack) begin
      word[PAY_W-1:0] = field;
      word[24]        = v;
      word[25]        = u;
      word[26]        = c;
      word[27]        = p;
      word[28]        = cs_b0b1;
      word[30:29]     = pre;
    end else if (width == WID_20) begin
      word[19:0] = payload[PAY_W-1:4];
    end else if (width == WID_16) begin
      word[HALF_W-1:0] = half;
    end else begin
      word[PAY_W-1:0] = field;
    end
  end

  // R7
  unpk_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pack |-> (word[31] == 1'b0));

  // R6
  mask16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pack && width == WID_16) |-> (word[7:0] == 8'h00));
endmodule

// File: rtl/sff_out.sv
module sff_out
  import sff_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pair16,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              keep,
  input  logic [WORD_W-1:0] word,
  input  logic [HALF_W-1:0] half,
  output logic              fire,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data
);
  logic              half_vld;
  logic [HALF_W-1:0] half_q;
  logic              take;

  assign s_ready = !m_valid || m_ready;
  assign fire    = s_valid && s_ready;
  assign take    = fire && keep && en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_data   <= '0;
      half_vld <= 1'b0;
      half_q   <= '0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (!en) begin
        half_vld <= 1'b0;
      end else if (take) begin
        if (pair16) begin
          if (half_vld) begin
            m_data   <= {half, half_q};
            m_valid  <= 1'b1;
            half_vld <= 1'b0;
          end else begin
            half_q   <= half;
            half_vld <= 1'b1;
          end
        end else begin
          m_data  <= word;
          m_valid <= 1'b1;
        end
      end
    end
  end

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R1
  dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(m_valid && !m_ready)) |=> !m_valid);
endmodule

// File: rtl/subframe_fmt.sv
module subframe_fmt
  import sff_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_en,
  input  logic        cfg_blk_gate,
  input  logic        cfg_vld_gate,
  input  logic        cfg_par_chk,
  input  logic [1:0]  cfg_width,
  input  logic        cfg_pack,
  input  logic        cfg_big_endian,
  input  logic        err_clr,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [23:0] s_payload,
  input  logic        s_v,
  input  logic        s_u,
  input  logic        s_c,
  input  logic        s_p,
  input  logic        s_cs_b0b1,
  input  logic [1:0]  s_pre,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [31:0] m_data,
  output logic        par_err
);
  logic              keep;
  logic              fire;
  logic [WORD_W-1:0] word;
  logic [HALF_W-1:0] half;
  logic              pair16;

  assign pair16 = cfg_pack && (cfg_width == WID_16);

  sff_gate i_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_en),
    .blk_gate (cfg_blk_gate),
    .vld_gate (cfg_vld_gate),
    .par_chk  (cfg_par_chk),
    .err_clr  (err_clr),
    .fire     (fire),
    .payload  (s_payload),
    .v        (s_v),
    .u        (s_u),
    .c        (s_c),
    .p        (s_p),
    .pre      (s_pre),
    .keep     (keep),
    .perr     (par_err)
  );

  sff_fmt i_fmt (
    .clk        (clk),
    .rst_n      (rst_n),
    .width      (cfg_width),
    .pack       (cfg_pack),
    .big_endian (cfg_big_endian),
    .payload    (s_payload),
    .v          (s_v),
    .u          (s_u),
    .c          (s_c),
    .p          (s_p),
    .cs_b0b1    (s_cs_b0b1),
    .pre        (s_pre),
    .word       (word),
    .half       (half)
  );

  sff_out i_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg_en),
    .pair16  (pair16),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .keep    (keep),
    .word    (word),
    .half    (half),
    .fire    (fire),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_data  (m_data)
  );
endmodule

// File: tb/test_subframe_fmt.sv
module test_subframe_fmt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_blk_gate = 1'b0, cfg_vld_gate = 1'b0, cfg_par_chk = 1'b0;
  logic [1:0]  cfg_width = 2'd0;
  logic        cfg_pack = 1'b0, cfg_big_endian = 1'b0, err_clr = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_payload = '0;
  logic        s_v = 1'b0, s_u = 1'b0, s_c = 1'b0, s_p = 1'b0, s_cs_b0b1 = 1'b0;
  logic [1:0]  s_pre = 2'd1;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [31:0] m_data;
  logic        par_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  subframe_fmt i_subframe_fmt (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] expq[$];
  bit          m_blk_seen;
  bit          m_half_vld;
  logic [15:0] m_half;
  bit          m_perr;
  string       tag;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] bswap(input logic [23:0] d);
    return {d[7:0], d[15:8], d[23:16]};
  endfunction

  // R6 / R10: payload field of a 24-bit-capable layout
  function automatic logic [23:0] field_of(input logic [23:0] d, input logic [1:0] w, input bit be);
    if (w == 2'd1) return {d[23:4], 4'h0};
    if (w == 2'd2) return {d[23:8], 8'h00};
    return be ? bswap(d) : d;
  endfunction

  // Model of one consumed subframe while the receiver is enabled
  task automatic model_take();
    bit isb, bad, kp;
    isb = (s_pre == 2'd0);
    bad = ^{s_payload, s_v, s_u, s_c, s_p};
    kp  = (!cfg_blk_gate || m_blk_seen || isb) && !(cfg_vld_gate && s_v) && !(cfg_par_chk && bad);
    if (isb) m_blk_seen = 1'b1;
    if (cfg_par_chk && bad) m_perr = 1'b1;
    else if (err_clr) m_perr = 1'b0;
    if (!kp) return;
    if (!cfg_pack) begin
      expq.push_back({1'b0, s_pre, s_cs_b0b1, s_p, s_c, s_u, s_v,
                      field_of(s_payload, cfg_width, cfg_big_endian)});
    end else if (cfg_width == 2'd1) begin
      expq.push_back({12'h0, s_payload[23:4]});
    end else if (cfg_width == 2'd2) begin
      if (m_half_vld) begin
        expq.push_back({s_payload[23:8], m_half});
        m_half_vld = 1'b0;
      end else begin
        m_half = s_payload[23:8];
        m_half_vld = 1'b1;
      end
    end else begin
      expq.push_back({8'h0, field_of(s_payload, cfg_width, cfg_big_endian)});
    end
  endtask

  // One cycle: drive at the falling edge, observe, predict, then wait for the edge
  task automatic step(input bit send, input int rdy_pct);
    logic [31:0] e;
    check("R5 par_err", {31'h0, par_err}, {31'h0, m_perr});
    m_ready = ($urandom % 100) < rdy_pct;
    s_valid = send && ($urandom % 4 != 0);
    s_payload = $urandom;
    s_v = ($urandom % 4 == 0);
    s_u = $urandom;
    s_c = $urandom;
    s_cs_b0b1 = $urandom;
    s_pre = ($urandom % 12 == 0) ? 2'd0 : 2'd1 + 2'($urandom % 2);
    s_p = ^{s_payload, s_v, s_u, s_c} ^ ($urandom % 8 == 0);
    #1;
    // R11
    check("R11 s_ready", {31'h0, s_ready}, {31'h0, (!m_valid || m_ready)});
    if (m_valid && m_ready) begin
      if (expq.size() == 0) begin
        check({tag, " unexpected word"}, m_data, 32'hxxxxxxxx);
      end else begin
        e = expq.pop_front();
        check(tag, m_data, e);
      end
    end
    if (s_valid && s_ready) begin
      if (cfg_en) model_take();
    end else if (err_clr && !(cfg_par_chk && 1'b0)) begin
      m_perr = 1'b0;
    end
    @(posedge clk);
    #(CLK_PERIOD/2 - 1);
  endtask

  task automatic run_phase(input bit en, input bit bg, input bit vg, input bit pc,
                           input logic [1:0] w, input bit pk, input bit be,
                           input string t, input int n);
    logic [31:0] held;
    // R1: leave enable low between phases, then apply the new settings
    s_valid = 1'b0;
    cfg_en = 1'b0;
    m_blk_seen = 1'b0;
    m_half_vld = 1'b0;
    repeat (2) step(1'b0, 100);
    cfg_blk_gate = bg; cfg_vld_gate = vg; cfg_par_chk = pc;
    cfg_width = w; cfg_pack = pk; cfg_big_endian = be;
    cfg_en = en;
    tag = t;
    for (int i = 0; i < n; i++) step(1'b1, 70);
    // R11: a stall must hold the word
    step(1'b1, 0);
    if (m_valid) begin
      held = m_data;
      step(1'b0, 0);
      check("R11 hold", m_data, held);
    end
    repeat (4) step(1'b0, 100);
    check({tag, " drained"}, {31'h0, (expq.size() == 0)}, 32'h1);
    // R5: clear the sticky flag
    err_clr = 1'b1;
    step(1'b0, 100);
    err_clr = 1'b0;
    step(1'b0, 100);
    check("R5 cleared", {31'h0, par_err}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2 - 1);
    rst_n = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/2 - 1);
    // Reset state
    check("R11 reset m_valid", {31'h0, m_valid}, 32'h0);
    check("R5 reset par_err", {31'h0, par_err}, 32'h0);
    check("R11 reset s_ready", {31'h0, s_ready}, 32'h1);

    run_phase(0, 0, 0, 0, 2'd0, 0, 0, "R1 disabled", 200);
    run_phase(1, 0, 0, 0, 2'd0, 0, 0, "R7 unpacked", 300);
    run_phase(1, 0, 0, 0, 2'd1, 0, 0, "R6 width20", 200);
    run_phase(1, 0, 0, 0, 2'd2, 0, 0, "R6 width16", 200);
    run_phase(1, 0, 0, 0, 2'd0, 0, 1, "R10 unpacked big", 200);
    run_phase(1, 1, 0, 0, 2'd0, 0, 0, "R2 block gate", 300);
    run_phase(1, 0, 1, 0, 2'd0, 0, 0, "R3 validity gate", 300);
    run_phase(1, 0, 0, 1, 2'd0, 0, 0, "R4 parity check", 300);
    run_phase(1, 0, 0, 0, 2'd0, 1, 0, "R8 packed24", 200);
    run_phase(1, 0, 0, 0, 2'd0, 1, 1, "R10 packed big", 200);
    run_phase(1, 0, 0, 0, 2'd1, 1, 0, "R8 packed20", 200);
    run_phase(1, 0, 0, 0, 2'd2, 1, 0, "R9 packed16", 400);
    run_phase(1, 1, 1, 1, 2'd2, 1, 0, "R9 packed16 gated", 400);
    run_phase(1, 0, 0, 0, 2'd3, 0, 1, "R6 width code 3", 200);
    for (int k = 0; k < 10; k++) begin
      run_phase(1, $urandom, $urandom, $urandom, 2'($urandom), $urandom, $urandom,
                "R2/R3/R4 random", 400);
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule